// File: doc/BRIEF.md
# Dual-Bank Sample Demultiplexer with Decimation

The block receives one sample per input clock and deals the stream out to two output banks, A and B, so that each bank changes at half the input rate. Alongside the banks it drives a forwarded data clock at half the input rate. A receiver latches bank A after that clock rises and bank B after it falls. The forwarded clock and both banks are registered outputs.

A test-mode input replaces the half-rate schedule with a ten-cycle frame. In that mode only two samples of every ten are kept: one for each bank. The output rate drops by five, and the forwarded clock stays at 50% duty. A phase-select input lets the system decide which input sample lands in bank A. Several instances can then be interleaved with a known relationship. When phase-select is held still, the block keeps its own alternation, and after reset that alternation starts with bank A.

Top module: `sample_demux`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears both banks to zero and drives `dataClk` low. The first sample taken after reset is released goes to bank A, unless phase-select forces otherwise.
- R2: In normal mode (`testMode` low), with `phaseSel` held constant, consecutive samples go alternately to bank A and bank B. A bank holds its value until its next load, so each bank changes at most once every two clocks.
- R3: `dataClk` goes high at the edge that loads bank A and goes low at the edge that loads bank B, and stays where it is otherwise.
- R4: In test mode, clock edges after reset are numbered from 0, and each edge's frame position is its number modulo 10. Bank A loads at position 0 and bank B loads at position 5. The samples at the other eight positions are discarded, and `dataClk` is high for five clocks and low for five.
- R5: `testMode` is sampled only at the edge at frame position 9 and takes effect from the next edge. A change at any other time has no effect until then.
- R6: In normal mode, if `phaseSel` at an edge differs from its value at the previous edge, the sample at that edge goes to bank A when `phaseSel` is 1 and to bank B when it is 0. Alternation then continues from that choice. After reset, the previous value of `phaseSel` is taken as 0.
- R7: In test mode, `phaseSel` has no effect on which samples are loaded or on `dataClk`.
- R8: After a return from test mode to normal mode, with `phaseSel` held constant, the first sample in normal mode goes to bank A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input sample clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | DATA_W (8) | Incoming sample, one per clock |
| testMode | input | 1 | 1 selects the decimated ten-cycle frame |
| phaseSel | input | 1 | Bank phase force; a change steers the sample (1 = A, 0 = B) |
| bankA | output | DATA_W (8) | Bank A register |
| bankB | output | DATA_W (8) | Bank B register |
| dataClk | output | 1 | Forwarded half-rate data clock |

## Verification
A steady `phaseSel` with random data shows whether the free-running alternation starts with bank A and keeps the two banks separate. A `phaseSel` toggling against the internal order shows whether forcing overrides the internal alternation. Mode changes placed at different frame positions separate a design that honours the frame boundary from one that switches at once. Random `phaseSel` during test mode, followed by a return to normal mode, shows that the decimated slots ignore phase forcing and that normal mode resumes on bank A.

// File: rtl/sdemux_pkg.sv
package sdemux_pkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic clkRise;
    logic clkFall;
  } strobe_t;
endpackage

// File: rtl/sdemux_ctrl.sv
module sdemux_ctrl
  import sdemux_pkg::*;
#(
  parameter int FRAME_LEN = 10,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             testMode,
  input  logic             phaseSel,
  output strobe_t          strb,
  output logic [CNT_W-1:0] frameCnt,
  output logic             decimMode
);
  localparam logic [CNT_W-1:0] FIRST_POS = '0;
  localparam logic [CNT_W-1:0] HALF_POS  = CNT_W'(FRAME_LEN / 2);
  localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(FRAME_LEN - 1);

  logic nextIsA;
  logic phasePrev;
  logic forced;
  logic slotA;

  // a change of phaseSel forces the bank choice for this sample
  always_comb begin
    forced = (phaseSel != phasePrev);
    slotA  = forced ? phaseSel : nextIsA;
  end

  always_comb begin
    strb = '0;
    if (decimMode) begin
      strb.loadA = (frameCnt == FIRST_POS);
      strb.loadB = (frameCnt == HALF_POS);
    end else begin
      strb.loadA = slotA;
      strb.loadB = !slotA;
    end
    strb.clkRise = strb.loadA;
    strb.clkFall = strb.loadB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frameCnt  <= '0;
      decimMode <= 1'b0;
      nextIsA   <= 1'b1;
      phasePrev <= 1'b0;
    end else begin
      frameCnt  <= (frameCnt == LAST_POS) ? '0 : frameCnt + 1'b1;
      phasePrev <= phaseSel;
      if (frameCnt == LAST_POS) decimMode <= testMode;
      if (decimMode) begin
        if (strb.loadA)      nextIsA <= 1'b0;
        else if (strb.loadB) nextIsA <= 1'b1;
      end else begin
        nextIsA <= !slotA;
      end
    end
  end
endmodule

// File: rtl/sdemux_datapath.sv
module sdemux_datapath
  import sdemux_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NUM_BANKS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] bankA,
  output logic [DATA_W-1:0] bankB,
  output logic              dataClk
);
  logic [NUM_BANKS-1:0] loadVec;
  logic [DATA_W-1:0]    bankQ [NUM_BANKS];

  assign loadVec = {strb.loadB, strb.loadA};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)             bankQ[b] <= '0;
      else if (loadVec[b]) bankQ[b] <= sampleIn;
    end
  end

  assign bankA = bankQ[0];
  assign bankB = bankQ[1];

  always_ff @(posedge clk) begin
    if (rst)               dataClk <= 1'b0;
    else if (strb.clkRise) dataClk <= 1'b1;
    else if (strb.clkFall) dataClk <= 1'b0;
  end
endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import sdemux_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 10,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              testMode,
  input  logic              phaseSel,
  output logic [DATA_W-1:0] bankA,
  output logic [DATA_W-1:0] bankB,
  output logic              dataClk
);
  strobe_t          strb;
  logic [CNT_W-1:0] frameCnt;
  logic             decimMode;

  sdemux_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .testMode(testMode), .phaseSel(phaseSel),
    .strb(strb), .frameCnt(frameCnt), .decimMode(decimMode)
  );

  sdemux_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .strb(strb),
    .bankA(bankA), .bankB(bankB), .dataClk(dataClk)
  );
endmodule

// File: rtl/sample_demux_chk.sv
module sample_demux_chk
  import sdemux_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FRAME_LEN = 10,
  localparam int CNT_W = $clog2(FRAME_LEN)
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bankA,
  input logic [DATA_W-1:0] bankB,
  input logic              dataClk,
  input strobe_t           strb,
  input logic [CNT_W-1:0]  frameCnt,
  input logic              decimMode
);
  localparam logic [CNT_W-1:0] HALF_POS = CNT_W'(FRAME_LEN / 2);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (bankA == '0 && bankB == '0 && !dataClk));

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    (bankA != $past(bankA)) |-> $stable(bankB));

  // R3
  a_rise_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadA |=> dataClk);

  // R3
  b_fall_chk: assert property (@(posedge clk) disable iff (rst)
    strb.loadB |=> !dataClk);

  // R4
  decim_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (decimMode && frameCnt != '0 && frameCnt != HALF_POS)
      |=> ($stable(bankA) && $stable(bankB) && $stable(dataClk)));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frameCnt != LAST_POS) |=> $stable(decimMode));
endmodule

bind sample_demux sample_demux_chk #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst(rst), .bankA(bankA), .bankB(bankB), .dataClk(dataClk),
  .strb(strb), .frameCnt(frameCnt), .decimMode(decimMode)
);

// File: tb/sim_sample_demux.sv
module sim_sample_demux;
  localparam int DW = 8;
  localparam int FL = 10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic [DW-1:0] sampleIn = '0;
  logic          testMode = 1'b0;
  logic          phaseSel = 1'b0;
  logic [DW-1:0] bankA, bankB;
  logic          dataClk;

  sample_demux #(.DATA_W(DW), .FRAME_LEN(FL)) u0 (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .testMode(testMode),
    .phaseSel(phaseSel), .bankA(bankA), .bankB(bankB), .dataClk(dataClk)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string tag = "R1";

  int      mCnt;
  bit      mDecim, mNextA, mPsPrev, mClk;
  logic [DW-1:0] mA, mB;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    mCnt = 0; mDecim = 0; mNextA = 1; mPsPrev = 0; mClk = 0; mA = '0; mB = '0;
  endtask

  task automatic compareAll();
    string ct;
    ct = (tag == "R2") ? "R3" : tag;
    chk(tag, "bankA", 32'(bankA), 32'(mA));
    chk(tag, "bankB", 32'(bankB), 32'(mB));
    chk(ct, "dataClk", 32'(dataClk), 32'(mClk));
  endtask

  // one clock: drive inputs, advance model from the requirements, sample at negedge
  task automatic step(logic [DW-1:0] d, bit tm, bit ps);
    bit forced, slotA, ldA, ldB;
    sampleIn = d; testMode = tm; phaseSel = ps;
    if (mDecim) begin
      ldA = (mCnt == 0);
      ldB = (mCnt == FL / 2);
    end else begin
      forced = (ps != mPsPrev);
      slotA  = forced ? ps : mNextA;
      ldA = slotA;
      ldB = !slotA;
    end
    if (ldA) begin mA = d; mClk = 1; end
    if (ldB) begin mB = d; mClk = 0; end
    if (mDecim) begin
      if (ldA) mNextA = 0;
      else if (ldB) mNextA = 1;
    end else begin
      mNextA = !ldA;
    end
    mPsPrev = ps;
    if (mCnt == FL - 1) mDecim = tm;
    mCnt = (mCnt == FL - 1) ? 0 : mCnt + 1;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    modelReset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ps;
    bit tm;
    void'($urandom(32'd20240611));
    @(negedge clk);
    doReset();
    // R1 reset state
    tag = "R1";
    chk("R1", "bankA", 32'(bankA), 32'h0);
    chk("R1", "bankB", 32'(bankB), 32'h0);
    chk("R1", "dataClk", 32'(dataClk), 32'h0);
    // R1 first sample lands in bank A
    step(8'h5A, 0, 0);
    chk("R1", "first A", 32'(bankA), 32'h5A);
    chk("R1", "first B", 32'(bankB), 32'h0);
    step(8'hC3, 0, 0);
    chk("R2", "second to B", 32'(bankB), 32'hC3);

    // R2 / R3 steady phaseSel, random data
    tag = "R2";
    for (int i = 0; i < 40; i++) step(8'($urandom), 0, 1'b0);

    // R6 toggling phaseSel against the internal order
    tag = "R6";
    ps = 1'b0;
    for (int i = 0; i < 30; i++) begin
      ps = !ps;
      step(8'($urandom), 0, ps);
    end
    // R6 single forced change while alternation runs
    for (int i = 0; i < 6; i++) step(8'($urandom), 0, ps);
    ps = !ps;
    step(8'hA7, 0, ps);
    if (ps) chk("R6", "forced A", 32'(bankA), 32'hA7);
    else    chk("R6", "forced B", 32'(bankB), 32'hA7);

    // R5 request test mode away from the frame boundary
    tag = "R5";
    while (mCnt != 3) step(8'($urandom), 0, ps);
    for (int i = 0; i < 12; i++) step(8'($urandom), 1, ps);

    // R4 decimated frames
    tag = "R4";
    for (int i = 0; i < 40; i++) step(8'($urandom), 1, ps);

    // R7 random phaseSel inside test mode
    tag = "R7";
    for (int i = 0; i < 40; i++) step(8'($urandom), 1, 1'($urandom));

    // R8 leave test mode with constant phaseSel
    tag = "R8";
    ps = 1'b0;
    while (mCnt != 7) step(8'($urandom), 1, ps);
    for (int i = 0; i < 20; i++) step(8'($urandom), 0, ps);

    // mixed random run
    tag = "R2";
    tm = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (($urandom % 97) == 0) tm = !tm;
      if (($urandom % 5) == 0) ps = !ps;
      step(8'($urandom), tm, ps);
    end

    // R1 reset in the middle of test mode
    tag = "R1";
    doReset();
    chk("R1", "reset A", 32'(bankA), 32'h0);
    chk("R1", "reset B", 32'(bankB), 32'h0);
    chk("R1", "reset clk", 32'(dataClk), 32'h0);
    step(8'h3C, 0, 0);
    chk("R1", "post reset A", 32'(bankA), 32'h3C);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule